// File: doc/BRIEF.md
# Nested Four-Level Interrupt Priority Arbiter

This block chooses which of a fixed set of interrupt request lines the processor should service next. Each source has its own enable bit and a pair of priority bits, one low-weight and one high-weight. Together these give the source one of four levels. A request is eligible only when its source enable and the global enable are both set. Among the eligible requests, the highest level wins. Within a level, the lowest source index wins.

The arbiter keeps a small stack of the levels now in service, so it knows when handlers are nested. It takes a new interrupt only when the stack is empty or when the candidate's level is strictly above the level on top of the stack. Taking an interrupt pushes its level onto the stack. A return-from-interrupt pulse pops the top entry. The outputs give a one-cycle take strobe, the index of the source taken, and the current in-service level with a valid flag. The processor uses these to vector and to mask.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After synchronous reset, `take_o` is 0, `in_service_o` is 0 and `cur_lvl_o` is 0.
- R2: A source's level is {prio_hi bit, prio_lo bit}, so 3 is the highest and 0 the lowest. Among eligible requests, one at a higher level is taken over one at a lower level, whatever their indices.
- R3: Among eligible requests at the same level, the one with the lowest source index is taken.
- R4: A request is taken only when its source enable bit and `glb_en_i` are both 1.
- R5: While a handler is in service, a request at the same level or at a lower level is not taken. A request at a strictly higher level is taken, and `cur_lvl_o` becomes that level.
- R6: While the in-service level is 3, no request is taken.
- R7: A request present before a clock edge produces `take_o`=1 in the cycle after that edge, and the outputs `take_src_o`, `cur_lvl_o` and `in_service_o` update in the same cycle. `take_o` lasts exactly one cycle per taken interrupt, and a request that stays asserted is not taken again while its level remains in service.
- R8: A `rti_i` pulse pops the stack and restores the previous in-service level. When the last entry is popped, `in_service_o` returns to 0. A `rti_i` pulse on an empty stack has no effect.
- R9: No interrupt is taken in a cycle where `rti_i` is high. A pending request is judged against the popped stack in the following cycle.
- R10: Nesting reaches `STACK_DEPTH` (4) levels, one per level from 0 to 3. Each level is restored in reverse order on successive returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_SRC | Interrupt request per source |
| src_en_i | input | NUM_SRC | Per-source enable |
| glb_en_i | input | 1 | Global interrupt enable |
| prio_lo_i | input | NUM_SRC | Low-weight priority bit per source |
| prio_hi_i | input | NUM_SRC | High-weight priority bit per source |
| rti_i | input | 1 | Return-from-interrupt pulse |
| take_o | output | 1 | One-cycle strobe: an interrupt was taken |
| take_src_o | output | IDX_W | Index of the source taken |
| cur_lvl_o | output | 2 | Level on top of the in-service stack (0 when empty) |
| in_service_o | output | 1 | At least one handler is in service |

## Verification
The hardest state to reach from the ports is a full four-deep nest, followed by an unwind that passes through every level and ends with a return on an empty stack. A count that underflows or a stale entry would only show up afterwards. The stimulus raises requests one at a time at levels 0, 1, 2 and 3, so each one preempts the previous handler. It then issues one extra return on the empty stack and checks that a single later take and a single return leave nothing in service. Ties, blocked equal-level requests and a return in the same cycle as a pending higher request are each driven by their own directed task.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 1 << LVL_W;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_level_decode.sv
// Forms each source's level from its two priority bits and builds one
// eligibility mask per level.
module irq_level_decode
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0]              req_i,
  input  logic [NUM_SRC-1:0]              src_en_i,
  input  logic                            glb_en_i,
  input  logic [NUM_SRC-1:0]              prio_lo_i,
  input  logic [NUM_SRC-1:0]              prio_hi_i,
  output logic [NUM_LVL-1:0][NUM_SRC-1:0] lvl_mask_o
);
  logic [NUM_SRC-1:0] elig;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    lvl_t src_lvl;
    assign src_lvl  = {prio_hi_i[s], prio_lo_i[s]};
    assign elig[s]  = req_i[s] & src_en_i[s] & glb_en_i;
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
      assign lvl_mask_o[l][s] = elig[s] && (src_lvl == lvl_t'(l));
    end
  end
endmodule

// File: rtl/irq_pick.sv
// Highest non-empty level wins; within it the lowest index wins.
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter  int NUM_SRC = 8,
  localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_LVL-1:0][NUM_SRC-1:0] lvl_mask_i,
  output logic                            hit_o,
  output lvl_t                            win_lvl_o,
  output logic [IDX_W-1:0]                win_idx_o
);
  always_comb begin
    hit_o     = 1'b0;
    win_lvl_o = '0;
    win_idx_o = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (|lvl_mask_i[l]) begin
        hit_o     = 1'b1;
        win_lvl_o = lvl_t'(l);
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
          if (lvl_mask_i[l][s]) win_idx_o = IDX_W'(s);
        end
      end
    end
  end
endmodule

// File: rtl/irq_nest_stack.sv
// Register stack of in-service levels.
module irq_nest_stack
  import irq_arb_pkg::*;
#(
  parameter  int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic push_i,
  input  lvl_t push_lvl_i,
  input  logic pop_i,
  output lvl_t top_lvl_o,
  output logic nonempty_o,
  output logic full_o
);
  lvl_t             lvl_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;

  assign nonempty_o = (cnt_q != '0);
  assign full_o     = (cnt_q == CNT_W'(DEPTH));

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) lvl_q[i] <= '0;
      else if (push_i && !full_o && cnt_q == CNT_W'(i)) lvl_q[i] <= push_lvl_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (push_i && !full_o) cnt_q <= cnt_q + 1'b1;
    else if (pop_i && nonempty_o) cnt_q <= cnt_q - 1'b1;
  end

  always_comb begin
    top_lvl_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == CNT_W'(i + 1)) top_lvl_o = lvl_q[i];
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push_i |-> !full_o);
  // R8
  pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && !nonempty_o) |=> !nonempty_o);
  // R5
  push_order_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && nonempty_o) |-> (push_lvl_i > top_lvl_o));
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter  int NUM_SRC     = 8,
  parameter  int STACK_DEPTH = 4,
  localparam int IDX_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic               glb_en_i,
  input  logic [NUM_SRC-1:0] prio_lo_i,
  input  logic [NUM_SRC-1:0] prio_hi_i,
  input  logic               rti_i,
  output logic               take_o,
  output logic [IDX_W-1:0]   take_src_o,
  output logic [LVL_W-1:0]   cur_lvl_o,
  output logic               in_service_o
);
  logic [NUM_LVL-1:0][NUM_SRC-1:0] lvl_mask;
  logic                            hit;
  lvl_t                            win_lvl;
  logic [IDX_W-1:0]                win_idx;
  lvl_t                            top_lvl;
  logic                            nonempty, full, grant;
  logic                            take_q;
  logic [IDX_W-1:0]                src_q;

  irq_level_decode #(.NUM_SRC(NUM_SRC)) u_dec (
    .req_i(req_i), .src_en_i(src_en_i), .glb_en_i(glb_en_i),
    .prio_lo_i(prio_lo_i), .prio_hi_i(prio_hi_i), .lvl_mask_o(lvl_mask)
  );

  irq_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .lvl_mask_i(lvl_mask), .hit_o(hit), .win_lvl_o(win_lvl), .win_idx_o(win_idx)
  );

  // Strict preemption, no take during a return cycle.
  assign grant = hit && !rti_i && !full && (!nonempty || (win_lvl > top_lvl));

  irq_nest_stack #(.DEPTH(STACK_DEPTH)) u_stk (
    .clk(clk), .rst(rst), .push_i(grant), .push_lvl_i(win_lvl),
    .pop_i(rti_i), .top_lvl_o(top_lvl), .nonempty_o(nonempty), .full_o(full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_q <= 1'b0;
      src_q  <= '0;
    end else begin
      take_q <= grant;
      if (grant) src_q <= win_idx;
    end
  end

  assign take_o       = take_q;
  assign take_src_o   = src_q;
  assign cur_lvl_o    = top_lvl;
  assign in_service_o = nonempty;

  // R7
  take_marks_service_chk: assert property (@(posedge clk) disable iff (rst)
    take_o |-> in_service_o);
  // R5
  strict_preempt_chk: assert property (@(posedge clk) disable iff (rst)
    (take_o && $past(in_service_o)) |-> (cur_lvl_o > $past(cur_lvl_o)));
  // R6
  top_level_block_chk: assert property (@(posedge clk) disable iff (rst)
    (in_service_o && cur_lvl_o == 2'd3) |=> !take_o);
  // R9
  rti_no_take_chk: assert property (@(posedge clk) disable iff (rst)
    rti_i |=> !take_o);
  // R4
  glb_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !glb_en_i |=> !take_o);
endmodule

// File: tb/irq_prio_arbiter_tb_top.sv
`timescale 1ns/1ps
module irq_prio_arbiter_tb_top;
  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  req, en, lo, hi;
  logic          gen, rti;
  logic          take_o;
  logic [IW-1:0] take_src_o;
  logic [1:0]    cur_lvl_o;
  logic          in_service_o;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  irq_prio_arbiter #(.NUM_SRC(N), .STACK_DEPTH(4)) dut_i (
    .clk(clk), .rst(rst), .req_i(req), .src_en_i(en), .glb_en_i(gen),
    .prio_lo_i(lo), .prio_hi_i(hi), .rti_i(rti), .take_o(take_o),
    .take_src_o(take_src_o), .cur_lvl_o(cur_lvl_o), .in_service_o(in_service_o)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_lvl(int s, int l);
    lo[s] = l[0];
    hi[s] = l[1];
  endtask

  // Checks the outputs after one edge.
  task automatic expect_out(string tag, int tk, int idx, int ins, int lvl);
    chk({tag, " take"}, int'(take_o), tk);
    if (tk != 0) chk({tag, " src"}, int'(take_src_o), idx);
    chk({tag, " in_service"}, int'(in_service_o), ins);
    if (ins != 0) chk({tag, " level"}, int'(cur_lvl_o), lvl);
  endtask

  task automatic do_rti();
    rti = 1'b1;
    tick();
    rti = 1'b0;
  endtask

  task automatic idle();
    req = '0; en = '1; gen = 1'b1; lo = '0; hi = '0; rti = 1'b0;
  endtask

  task automatic t_reset();
    expect_out("R1 reset", 0, 0, 0, 0);
    chk("R1 level", int'(cur_lvl_o), 0);
  endtask

  task automatic t_level_wins();
    idle();
    set_lvl(6, 2); set_lvl(1, 1); set_lvl(0, 0);
    req[6] = 1; req[1] = 1; req[0] = 1;
    tick(); expect_out("R2 higher level wins", 1, 6, 1, 2);
    tick(); expect_out("R7 single pulse", 0, 0, 1, 2);
    tick(); expect_out("R5 lower held", 0, 0, 1, 2);
    req[6] = 0;
    do_rti(); expect_out("R9 rti cycle no take", 0, 0, 0, 0);
    tick(); expect_out("R9 pending taken after rti", 1, 1, 1, 1);
    req[1] = 0; req[0] = 0;
    do_rti(); expect_out("R8 empty", 0, 0, 0, 0);
  endtask

  task automatic t_tie();
    idle();
    set_lvl(3, 1); set_lvl(5, 1);
    req[3] = 1; req[5] = 1;
    tick(); expect_out("R3 lowest index", 1, 3, 1, 1);
    tick(); expect_out("R5 same level blocked", 0, 0, 1, 1);
    req[3] = 0;
    do_rti(); expect_out("R9 rti", 0, 0, 0, 0);
    tick(); expect_out("R3 next in poll", 1, 5, 1, 1);
    req[5] = 0;
    do_rti(); expect_out("R8 empty", 0, 0, 0, 0);
  endtask

  task automatic t_enable();
    idle();
    set_lvl(2, 3); set_lvl(0, 3); set_lvl(7, 2);
    req[2] = 1; en[2] = 0;
    tick(); expect_out("R4 source disabled", 0, 0, 0, 0);
    en[2] = 1; gen = 0;
    tick(); expect_out("R4 global disabled", 0, 0, 0, 0);
    gen = 1;
    tick(); expect_out("R4 both enabled", 1, 2, 1, 3);
    req[0] = 1; req[7] = 1;
    for (int k = 0; k < 3; k++) begin
      tick(); expect_out("R6 level 3 not preempted", 0, 0, 1, 3);
    end
    req = '0;
    do_rti(); expect_out("R8 empty", 0, 0, 0, 0);
  endtask

  task automatic t_preempt();
    idle();
    set_lvl(4, 1); set_lvl(0, 1); set_lvl(7, 0); set_lvl(6, 2);
    req[4] = 1;
    tick(); expect_out("R5 first", 1, 4, 1, 1);
    req[0] = 1;
    tick(); expect_out("R5 equal lower index blocked", 0, 0, 1, 1);
    req[7] = 1;
    tick(); expect_out("R5 lower level blocked", 0, 0, 1, 1);
    req[6] = 1;
    tick(); expect_out("R5 higher preempts", 1, 6, 1, 2);
    req = '0;
    do_rti(); expect_out("R8 restore level 1", 0, 0, 1, 1);
    do_rti(); expect_out("R8 empty", 0, 0, 0, 0);
  endtask

  task automatic t_nest();
    idle();
    for (int l = 0; l < 4; l++) begin
      set_lvl(l + 1, l);
      req[l + 1] = 1;
      tick(); expect_out("R10 nest push", 1, l + 1, 1, l);
    end
    req = '0;
    for (int l = 2; l >= 0; l--) begin
      do_rti(); expect_out("R10 unwind", 0, 0, 1, l);
    end
    do_rti(); expect_out("R8 last pop", 0, 0, 0, 0);
    do_rti(); expect_out("R8 rti on empty ignored", 0, 0, 0, 0);
    set_lvl(5, 1); req[5] = 1;
    tick(); expect_out("R8 take after empty rti", 1, 5, 1, 1);
    req = '0;
    do_rti(); expect_out("R8 no underflow", 0, 0, 0, 0);
  endtask

  initial begin
    idle();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_level_wins();
    t_tie();
    t_enable();
    t_preempt();
    t_nest();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule